// File: doc/BRIEF.md
# Sliding-Window Register File

This block is a register file of 128 physical entries that instructions see through a 32-entry logical window. Logical registers 0 to 7 are shared globals. They land on physical 0 to 7 whatever the window position. Logical registers 8 to 31 are local to the window. They are found by adding a movable window base to the logical number, with a wrap inside the 120 local entries. Only one window is active at a time, and a base-set command moves it.

Two extra ports serve memory traffic that runs ahead of the instruction stream. A fill port writes data from memory into a local register given as a signed offset from the current base. A drain port reads a local register given the same way, so its value can be stored out. Because the offset is signed, both ports can reach registers outside the active window. A later window can therefore be filled while the current one is still in use, and an earlier one can be emptied.

Top module: `swin_regfile`

## Requirements
- R1: After reset the window base is 0 and every physical register reads as zero.
- R2: Logical registers 0 to 7 address physical registers 0 to 7 for every base value, so a global written under one base reads back under any other base.
- R3: A logical register r of 8 or above addresses physical register 8 + ((base + r - 8) mod 120), wrapping within the local region.
- R4: A base-set command loads the base at the clock edge. Reads in the same cycle still use the old base. A loaded value v of 120 or more is taken as v - 120.
- R5: The write port updates its register at the clock edge. A read port that addresses the same physical register in the same cycle returns the new data.
- R6: The fill port writes physical register 8 + ((base + off) mod 120), where off is a signed 8-bit two's-complement value. The result of the mod is taken in 0..119. Same-cycle reads of that register return the fill data.
- R7: The drain port returns, with no clock delay, the contents of physical register 8 + ((base + off) mod 120) for its signed 8-bit offset, with the same bypass as the read ports.
- R8: When the write port and the fill port hit the same physical register in one cycle, the write port's data is stored and bypassed.
- R9: Local registers are private to a base position. A write to a local register under one base leaves unchanged the registers that a different base maps that logical number to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_idx | input | 5 | Logical index, read port 0 |
| rd0_data | output | 32 | Data, read port 0 |
| rd1_idx | input | 5 | Logical index, read port 1 |
| rd1_data | output | 32 | Data, read port 1 |
| wr_en | input | 1 | Write strobe, instruction port |
| wr_idx | input | 5 | Logical index, instruction write |
| wr_data | input | 32 | Data, instruction write |
| base_set | input | 1 | Load a new window base |
| base_val | input | 7 | New window base |
| fill_en | input | 1 | Write strobe, fill port |
| fill_off | input | 8 | Signed offset from base, fill port |
| fill_data | input | 32 | Data, fill port |
| drain_off | input | 8 | Signed offset from base, drain port |
| drain_data | output | 32 | Data, drain port |

## Verification
Directed patterns come first. Globals are written under one base and read under another, which separates the shared region from the local one. Locals are written near the top of the local region and read back under a base that reaches them through the wrap, which exposes a missing or off-by-one modulo. Fill and drain are tried with negative and large positive offsets. A base-set is given together with a read, which tells the old-base timing from the new-base timing. Write and fill collisions on one register show which port wins, and a run of random cycles with a reference model covers the mix of all ports.

// File: rtl/swin_regfile.sv
module swin_regfile #(
  parameter int NREG = 128,
  parameter int NWIN = 32,
  parameter int NGLB = 8,
  parameter int DW   = 32,
  parameter int OW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NWIN)-1:0] rd0_idx,
  output logic [DW-1:0]           rd0_data,
  input  logic [$clog2(NWIN)-1:0] rd1_idx,
  output logic [DW-1:0]           rd1_data,
  input  logic                    wr_en,
  input  logic [$clog2(NWIN)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    base_set,
  input  logic [$clog2(NREG)-1:0] base_val,
  input  logic                    fill_en,
  input  logic [OW-1:0]           fill_off,
  input  logic [DW-1:0]           fill_data,
  input  logic [OW-1:0]           drain_off,
  output logic [DW-1:0]           drain_data
);
  localparam int NLOC = NREG - NGLB;
  localparam int PW   = $clog2(NREG);
  localparam int IW   = $clog2(NWIN);

  logic [DW-1:0] regs [NREG];
  logic [PW-1:0] base_q;
  logic [PW-1:0] rd0_pa, rd1_pa, wr_pa, fill_pa, drain_pa;

  function automatic logic [PW-1:0] win_map(input logic [PW-1:0] b, input logic [IW-1:0] r);
    int t;
    if (int'(r) < NGLB) return PW'(r);
    t = (int'(b) + int'(r) - NGLB) % NLOC;
    return PW'(NGLB + t);
  endfunction

  function automatic logic [PW-1:0] off_map(input logic [PW-1:0] b, input logic [OW-1:0] o);
    int t;
    t = (int'(b) + int'($signed(o))) % NLOC;
    if (t < 0) t = t + NLOC;
    return PW'(NGLB + t);
  endfunction

  function automatic logic [DW-1:0] fetch(input logic [PW-1:0] pa);
    if (wr_en && wr_pa == pa) return wr_data;
    if (fill_en && fill_pa == pa) return fill_data;
    return regs[pa];
  endfunction

  assign rd0_pa   = win_map(base_q, rd0_idx);
  assign rd1_pa   = win_map(base_q, rd1_idx);
  assign wr_pa    = win_map(base_q, wr_idx);
  assign fill_pa  = off_map(base_q, fill_off);
  assign drain_pa = off_map(base_q, drain_off);

  assign rd0_data   = fetch(rd0_pa);
  assign rd1_data   = fetch(rd1_pa);
  assign drain_data = fetch(drain_pa);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (base_set) base_q <= PW'(int'(base_val) % NLOC);
      if (fill_en) regs[fill_pa] <= fill_data;
      if (wr_en) regs[wr_pa] <= wr_data;
    end
  end

  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(base_q) < NLOC); // R4
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !base_set |=> $stable(base_q)); // R4
  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    base_set && int'(base_val) < NLOC |=> base_q == $past(base_val)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_pa)] == $past(wr_data)); // R5
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !(wr_en && wr_pa == fill_pa) |=> regs[$past(fill_pa)] == $past(fill_data)); // R6
  AST_GLOBAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd0_idx) < NGLB |-> rd0_pa == PW'(rd0_idx)); // R2
  AST_LOCAL_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd1_idx) >= NGLB |-> int'(rd1_pa) >= NGLB); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && fill_en && wr_pa == fill_pa |-> drain_pa != fill_pa || drain_data == wr_data); // R8
endmodule

// File: tb/swin_regfile_bench.sv
module swin_regfile_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [31:0] rd0_data, rd1_data, drain_data, wr_data = 0, fill_data = 0;
  logic wr_en = 0, base_set = 0, fill_en = 0;
  logic [6:0] base_val = 0;
  logic [7:0] fill_off = 0, drain_off = 0;

  swin_regfile u_swin_regfile (.*);

  always #2 clk = ~clk;

  typedef struct {
    int req;
    logic [31:0] e0, e1, e2;
  } item_t;
  item_t q[$];

  logic [31:0] mdl [128];
  int mbase = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int lmap(int b, int r);
    if (r < 8) return r;
    return 8 + ((b + r - 8) % 120);
  endfunction

  function automatic int omap(int b, logic [7:0] o);
    int t;
    t = (b + int'($signed(o))) % 120;
    if (t < 0) t += 120;
    return 8 + t;
  endfunction

  function automatic logic [31:0] bval(int pa);
    if (wr_en && lmap(mbase, int'(wr_idx)) == pa) return wr_data;
    if (fill_en && omap(mbase, fill_off) == pa) return fill_data;
    return mdl[pa];
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; fill_en = 0; base_set = 0;
  endtask

  task automatic expect_now(int req);
    item_t it;
    it.req = req;
    it.e0 = bval(lmap(mbase, int'(rd0_idx)));
    it.e1 = bval(lmap(mbase, int'(rd1_idx)));
    it.e2 = bval(omap(mbase, drain_off));
    q.push_back(it);
    if (fill_en) mdl[omap(mbase, fill_off)] = fill_data;
    if (wr_en) mdl[lmap(mbase, int'(wr_idx))] = wr_data;
    if (base_set) mbase = int'(base_val) % 120;
  endtask

  task automatic cmp(int req, string nm, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, nm, a, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cmp(it.req, "rd0", rd0_data, it.e0);
        cmp(it.req, "rd1", rd1_data, it.e1);
        cmp(it.req, "drain", drain_data, it.e2);
      end
    end
  end

  task automatic setbase(int req, int v);
    tick(); base_set = 1; base_val = 7'(v); expect_now(req);
  endtask

  task automatic wr(int req, int r, logic [31:0] d);
    tick(); wr_en = 1; wr_idx = 5'(r); wr_data = d; expect_now(req);
  endtask

  task automatic rd(int req, int a, int b, int o);
    tick(); rd0_idx = 5'(a); rd1_idx = 5'(b); drain_off = 8'(o); expect_now(req);
  endtask

  initial begin : driver
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    rd(1, 0, 31, 0);
    rd(1, 7, 20, -5);
    // R2: globals shared across bases
    wr(2, 3, 32'hA0A0_0003);
    setbase(2, 50);
    rd(2, 3, 8, 0);
    // R3: local mapping and wrap; R9 privacy
    wr(3, 10, 32'hB000_0010);
    setbase(3, 52);
    rd(3, 8, 10, 0);
    rd(9, 10, 12, 0);
    setbase(3, 115);
    wr(3, 31, 32'hC000_0026);
    setbase(3, 10);
    rd(3, 16, 31, 18);
    // R4: base-set with same-cycle read uses old base, then new
    tick(); base_set = 1; base_val = 7'd8; rd0_idx = 5'd16; rd1_idx = 5'd8; drain_off = 8'd0; expect_now(4);
    rd(4, 16, 8, 0);
    setbase(4, 125);
    rd(4, 8, 9, 0);
    // R5: write with same-cycle bypass
    tick(); wr_en = 1; wr_idx = 5'd12; wr_data = 32'hD000_000C; rd0_idx = 5'd12; rd1_idx = 5'd2; expect_now(5);
    rd(5, 12, 3, 0);
    // R6: fill with negative offset wraps to top; R7 drain
    setbase(6, 2);
    tick(); fill_en = 1; fill_off = 8'hFD; fill_data = 32'hE000_007F; drain_off = 8'hFD; expect_now(6);
    setbase(6, 112);
    rd(6, 15, 8, 7);
    setbase(7, 30);
    tick(); fill_en = 1; fill_off = 8'd100; fill_data = 32'h1234_5678; expect_now(6);
    rd(7, 8, 9, 100);
    rd(7, 0, 1, -128);
    rd(7, 2, 3, 127);
    // R8: collision of write and fill on one register
    tick(); wr_en = 1; wr_idx = 5'd9; wr_data = 32'hAAAA_5555;
    fill_en = 1; fill_off = 8'd1; fill_data = 32'h5555_AAAA; rd0_idx = 5'd9; drain_off = 8'd1; expect_now(8);
    rd(8, 9, 8, 1);
    // R3: random mixed traffic against model
    for (int k = 0; k < 400; k++) begin
      tick();
      rd0_idx = 5'($urandom); rd1_idx = 5'($urandom); drain_off = 8'($urandom);
      wr_en = $urandom_range(0, 1) == 1; wr_idx = 5'($urandom); wr_data = $urandom;
      fill_en = $urandom_range(0, 2) == 0; fill_off = 8'($urandom); fill_data = $urandom;
      base_set = $urandom_range(0, 7) == 0; base_val = 7'($urandom);
      expect_now(3);
    end
    tick();
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule